// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between the decode stage and the data memory port of a 32-bit integer core. For each memory request it adds the base register to the sign-extended 16-bit displacement, classifies the opcode into byte, halfword or word access, checks natural alignment, and either issues a memory strobe or flags an address error that tells loads and stores apart. Opcodes for doubleword, linked-load and conditional-store operations are flagged as reserved, and the unit issues no strobe and raises no address error for them.

When a load has been issued, the unit remembers how its result must be widened. The memory answers later with data aligned to the low bits of the bus. The unit then sign- or zero-extends the useful byte or halfword, or passes a word through, and presents the 32-bit result one cycle after the response. The response of one load may arrive in the same cycle as the next request is decoded.

Top module: `lsu_agu_ext`

## Requirements
- R1: `eff_addr` equals `req_base` plus `req_offset` sign-extended from bit 15, modulo 2^32, in the same cycle as the request.
- R2: `acc_size` is 2'b00 for byte, 2'b01 for halfword and 2'b10 for word opcodes.
- R3: A halfword request (opcodes 0x21, 0x25, 0x29) whose address has bit 0 set raises `addr_err`, drives `err_addr` with that address and issues no `mem_strobe`.
- R4: A word request (opcodes 0x23, 0x2B) whose address has bit 1 or bit 0 set raises `addr_err`, and no strobe is issued. A strobed word access always has address bits 1..0 at zero.
- R5: Byte requests (opcodes 0x20, 0x24, 0x28) never raise `addr_err`, whatever the address.
- R6: `err_is_store` is 1 with an address error from a store opcode (0x28, 0x29, 0x2B) and 0 with one from a load opcode.
- R7: A valid, aligned memory request asserts `mem_strobe` in the request cycle. `mem_write` is high for store opcodes and low for loads.
- R8: Opcodes 0x1A, 0x1B, 0x2C, 0x2D, 0x30, 0x34, 0x37, 0x38, 0x3C and 0x3F assert `rsv_instr` and raise neither `mem_strobe` nor `addr_err`.
- R9: For opcode 0x20 the result is bits 7..0 of the response, sign-extended from bit 7. For opcode 0x24 those bits are zero-extended.
- R10: For opcode 0x21 the result is bits 15..0 of the response, sign-extended from bit 15. For opcode 0x25 those bits are zero-extended.
- R11: For opcode 0x23 the response passes unchanged. `ld_valid` rises in the cycle after `rsp_valid`, with `ld_data` valid alongside it.
- R12: After reset, and for a `rsp_valid` that has no issued load outstanding, `ld_valid` stays low.
- R13: With `req_valid` low, `mem_strobe`, `addr_err` and `rsv_instr` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 6 | Memory operation opcode |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| eff_addr | output | 32 | Effective address |
| acc_size | output | 2 | Access size code |
| mem_strobe | output | 1 | Memory access issued |
| mem_write | output | 1 | Issued access is a store |
| addr_err | output | 1 | Misaligned access |
| err_is_store | output | 1 | Faulting access was a store |
| err_addr | output | 32 | Faulting address, zero otherwise |
| rsv_instr | output | 1 | Reserved opcode seen |
| rsp_valid | input | 1 | Memory load data present |
| rsp_data | input | 32 | Raw load data, low-aligned |
| ld_valid | output | 1 | Extended load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The two functions that share a cycle are the widening of an outstanding load's response and the decode and alignment check of the next request. The bench issues a load. It returns that load's data in the same cycle as it presents either a misaligned store or a fresh aligned load. The error flags or the new strobe are judged in that cycle. The first result is judged one cycle later against the extension type of the older load. In the second case the data of the younger load is then returned and judged against its own type.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  typedef enum logic [2:0] {
    EXT_BYTE_S,
    EXT_BYTE_U,
    EXT_HALF_S,
    EXT_HALF_U,
    EXT_WORD
  } ext_kind_e;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LDB_S = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LDH_S = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LDW   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_LDB_U = 6'h24;
  localparam logic [OPC_W-1:0] OPC_LDH_U = 6'h25;
  localparam logic [OPC_W-1:0] OPC_STB   = 6'h28;
  localparam logic [OPC_W-1:0] OPC_STH   = 6'h29;
  localparam logic [OPC_W-1:0] OPC_STW   = 6'h2B;

  typedef struct packed {
    logic      is_mem;
    logic      is_store;
    logic      is_rsv;
    acc_size_e size;
    ext_kind_e kind;
  } op_info_t;

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
  import lsu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_info_t         info
);

  always_comb begin
    info          = '0;
    info.size     = SZ_BYTE;
    info.kind     = EXT_WORD;
    unique case (opcode)
      OPC_LDB_S: begin info.is_mem = 1'b1; info.size = SZ_BYTE; info.kind = EXT_BYTE_S; end
      OPC_LDB_U: begin info.is_mem = 1'b1; info.size = SZ_BYTE; info.kind = EXT_BYTE_U; end
      OPC_LDH_S: begin info.is_mem = 1'b1; info.size = SZ_HALF; info.kind = EXT_HALF_S; end
      OPC_LDH_U: begin info.is_mem = 1'b1; info.size = SZ_HALF; info.kind = EXT_HALF_U; end
      OPC_LDW:   begin info.is_mem = 1'b1; info.size = SZ_WORD; info.kind = EXT_WORD;   end
      OPC_STB:   begin info.is_mem = 1'b1; info.is_store = 1'b1; info.size = SZ_BYTE; end
      OPC_STH:   begin info.is_mem = 1'b1; info.is_store = 1'b1; info.size = SZ_HALF; end
      OPC_STW:   begin info.is_mem = 1'b1; info.is_store = 1'b1; info.size = SZ_WORD; end
      6'h1A, 6'h1B, 6'h2C, 6'h2D, 6'h30,
      6'h34, 6'h37, 6'h38, 6'h3C, 6'h3F:
                 begin info.is_rsv = 1'b1; end
      default:   begin info = info; end
    endcase
  end

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic [AW-1:0]   base,
  input  logic [OFFW-1:0] offset,
  input  acc_size_e       size,
  output logic [AW-1:0]   ea,
  output logic            misalign
);

  localparam int EXTW = AW - OFFW;

  logic [AW-1:0] off_sx;

  generate
    if (EXTW > 0) begin : g_sext
      assign off_sx = {{EXTW{offset[OFFW-1]}}, offset};
    end else begin : g_trunc
      assign off_sx = offset[AW-1:0];
    end
  endgenerate

  assign ea = base + off_sx;

  always_comb begin
    unique case (size)
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = |ea[1:0];
      default: misalign = 1'b0;
    endcase
  end

  AST_BYTE_NEVER_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && size == SZ_BYTE) |-> !misalign); // R5

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  ext_kind_e     issue_kind,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          ld_valid,
  output logic [DW-1:0] ld_data
);

  localparam int BW = 8;
  localparam int HW = 16;

  logic          pend_q, pend_d;
  ext_kind_e     kind_q, kind_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;
  logic [DW-1:0] widened;

  always_comb begin
    unique case (kind_q)
      EXT_BYTE_S: widened = {{(DW-BW){rsp_data[BW-1]}}, rsp_data[BW-1:0]};
      EXT_BYTE_U: widened = {{(DW-BW){1'b0}},           rsp_data[BW-1:0]};
      EXT_HALF_S: widened = {{(DW-HW){rsp_data[HW-1]}}, rsp_data[HW-1:0]};
      EXT_HALF_U: widened = {{(DW-HW){1'b0}},           rsp_data[HW-1:0]};
      default:    widened = rsp_data;
    endcase
  end

  always_comb begin
    pend_d  = pend_q;
    kind_d  = kind_q;
    if (rsp_valid) pend_d = 1'b0;
    if (issue) begin
      pend_d = 1'b1;
      kind_d = issue_kind;
    end
    vld_d   = rsp_valid & pend_q;
    data_en = vld_d;
    data_d  = widened;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= EXT_WORD;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      vld_q  <= vld_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign ld_valid = vld_q;
  assign ld_data  = data_q;

  AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(rsp_valid)); // R11

  AST_NO_ORPHAN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(pend_q)); // R12

endmodule

// File: rtl/lsu_agu_ext.sv
module lsu_agu_ext
  import lsu_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int OFFW       = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [OPC_W-1:0] req_opcode,
  input  logic [AW-1:0]    req_base,
  input  logic [OFFW-1:0]  req_offset,
  output logic [AW-1:0]    eff_addr,
  output logic [1:0]       acc_size,
  output logic             mem_strobe,
  output logic             mem_write,
  output logic             addr_err,
  output logic             err_is_store,
  output logic [AW-1:0]    err_addr,
  output logic             rsv_instr,
  input  logic             rsp_valid,
  input  logic [DW-1:0]    rsp_data,
  output logic             ld_valid,
  output logic [DW-1:0]    ld_data
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  op_info_t      info;
  logic          chk_en;
  logic          misalign;
  logic [AW-1:0] ea;
  logic          load_issue;

  lsu_op_decode u_dec (
    .opcode (req_opcode),
    .info   (info)
  );

  assign chk_en = req_valid & info.is_mem;

  lsu_addr_gen #(.AW(AW), .OFFW(OFFW)) u_agen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chk_en   (chk_en),
    .base     (req_base),
    .offset   (req_offset),
    .size     (info.size),
    .ea       (ea),
    .misalign (misalign)
  );

  assign eff_addr     = ea;
  assign acc_size     = info.size;
  assign addr_err     = chk_en & misalign;
  assign mem_strobe   = chk_en & ~misalign;
  assign mem_write    = mem_strobe & info.is_store;
  assign err_is_store = addr_err & info.is_store;
  assign err_addr     = addr_err ? ea : '0;
  assign rsv_instr    = req_valid & info.is_rsv;
  assign load_issue   = mem_strobe & ~info.is_store;

  lsu_load_ext #(.DW(DW)) u_ext (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .issue      (load_issue),
    .issue_kind (info.kind),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data)
  );

  AST_ERR_BLOCKS_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    addr_err |-> !mem_strobe); // R3

  AST_WORD_STROBE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_strobe && acc_size == SZ_WORD) |-> (eff_addr[1:0] == 2'b00)); // R4

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsv_instr |-> !(mem_strobe || addr_err)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |-> !(mem_strobe || addr_err || rsv_instr)); // R13

endmodule

// File: tb/tb_lsu_agu_ext.sv
module tb_lsu_agu_ext;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  req_opcode;
  logic [31:0] req_base;
  logic [15:0] req_offset;
  logic [31:0] eff_addr;
  logic [1:0]  acc_size;
  logic        mem_strobe, mem_write, addr_err, err_is_store, rsv_instr;
  logic [31:0] err_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        ld_valid;
  logic [31:0] ld_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  lsu_agu_ext dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_offset(req_offset), .eff_addr(eff_addr),
    .acc_size(acc_size), .mem_strobe(mem_strobe), .mem_write(mem_write),
    .addr_err(addr_err), .err_is_store(err_is_store), .err_addr(err_addr),
    .rsv_instr(rsv_instr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // {opcode, base, offset, rdata, exp_err, exp_strobe, exp_rsv}
  localparam int NV = 16;
  localparam logic [88:0] VECS [NV] = '{
    {6'h20, 32'h0000_1000, 16'h0003, 32'h0000_00F5, 1'b0, 1'b1, 1'b0},
    {6'h24, 32'h0000_1000, 16'h0003, 32'h0000_00F5, 1'b0, 1'b1, 1'b0},
    {6'h21, 32'h0000_2000, 16'hFFFE, 32'h0000_8001, 1'b0, 1'b1, 1'b0},
    {6'h25, 32'h0000_2000, 16'hFFFE, 32'h0000_8001, 1'b0, 1'b1, 1'b0},
    {6'h21, 32'h0000_2000, 16'h0001, 32'h0,         1'b1, 1'b0, 1'b0},
    {6'h23, 32'h0000_3000, 16'h0004, 32'h8000_0001, 1'b0, 1'b1, 1'b0},
    {6'h23, 32'h0000_3000, 16'h0002, 32'h0,         1'b1, 1'b0, 1'b0},
    {6'h2B, 32'h0000_3000, 16'h0003, 32'h0,         1'b1, 1'b0, 1'b0},
    {6'h29, 32'h0000_4000, 16'h0005, 32'h0,         1'b1, 1'b0, 1'b0},
    {6'h28, 32'h0000_4001, 16'h0000, 32'h0,         1'b0, 1'b1, 1'b0},
    {6'h2B, 32'hFFFF_FFFC, 16'h0004, 32'h0,         1'b0, 1'b1, 1'b0},
    {6'h37, 32'h0000_5000, 16'h0001, 32'h0,         1'b0, 1'b0, 1'b1},
    {6'h30, 32'h0000_5000, 16'h0000, 32'h0,         1'b0, 1'b0, 1'b1},
    {6'h38, 32'h0000_5003, 16'h0000, 32'h0,         1'b0, 1'b0, 1'b1},
    {6'h20, 32'h0000_5000, 16'h7FFF, 32'h0000_007F, 1'b0, 1'b1, 1'b0},
    {6'h25, 32'h0000_6000, 16'h0002, 32'hABCD_1234, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ea(input logic [31:0] b, input logic [15:0] o);
    logic [31:0] s;
    s = o[15] ? (32'hFFFF_0000 | 32'(o)) : 32'(o);
    return b + s;
  endfunction

  function automatic logic [1:0] exp_size(input logic [5:0] op);
    case (op)
      6'h21, 6'h25, 6'h29: return 2'b01;
      6'h23, 6'h2B:        return 2'b10;
      default:             return 2'b00;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(input logic [5:0] op, input logic [31:0] d);
    case (op)
      6'h20:   return d[7]  ? (32'hFFFF_FF00 | {24'h0, d[7:0]})  : {24'h0, d[7:0]};
      6'h24:   return {24'h0, d[7:0]};
      6'h21:   return d[15] ? (32'hFFFF_0000 | {16'h0, d[15:0]}) : {16'h0, d[15:0]};
      6'h25:   return {16'h0, d[15:0]};
      default: return d;
    endcase
  endfunction

  function automatic bit is_store_op(input logic [5:0] op);
    return (op == 6'h28) || (op == 6'h29) || (op == 6'h2B);
  endfunction

  task automatic drive_req(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o);
    req_valid  = 1'b1;
    req_opcode = op;
    req_base   = b;
    req_offset = o;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_opcode = 6'h0;
    req_base   = '0;
    req_offset = '0;
    rsp_valid  = 1'b0;
    rsp_data   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R12", "ld_valid after reset", 32'(ld_valid), 32'd0);
    chk("R13", "idle strobe/err/rsv", {29'd0, mem_strobe, addr_err, rsv_instr}, 32'd0);

    // R12: response with nothing outstanding produces no result
    rsp_valid = 1'b1; rsp_data = 32'h1234_5678;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R12", "orphan response ld_valid", 32'(ld_valid), 32'd0);

    // R13: load opcode with req_valid low
    req_opcode = 6'h23; req_base = 32'h0000_0002; req_offset = 16'h0;
    #1;
    chk("R13", "no strobe when idle", {30'd0, mem_strobe, addr_err}, 32'd0);
    @(negedge clk);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [5:0]  op;
      logic [31:0] b, rd;
      logic [15:0] o;
      logic        e_err, e_stb, e_rsv;
      {op, b, o, rd, e_err, e_stb, e_rsv} = VECS[i];
      drive_req(op, b, o);
      #1;
      chk("R1", $sformatf("vec%0d eff_addr", i), eff_addr, exp_ea(b, o));
      if (!e_rsv)
        chk("R2", $sformatf("vec%0d acc_size", i), 32'(acc_size), 32'(exp_size(op)));
      chk(e_rsv ? "R8" : (exp_size(op) == 2'b00 ? "R5" : (exp_size(op) == 2'b01 ? "R3" : "R4")),
          $sformatf("vec%0d addr_err", i), 32'(addr_err), 32'(e_err));
      chk("R7", $sformatf("vec%0d mem_strobe", i), 32'(mem_strobe), 32'(e_stb));
      chk("R7", $sformatf("vec%0d mem_write", i), 32'(mem_write), 32'(e_stb & is_store_op(op)));
      chk("R8", $sformatf("vec%0d rsv_instr", i), 32'(rsv_instr), 32'(e_rsv));
      if (e_err) begin
        chk("R6", $sformatf("vec%0d err_is_store", i), 32'(err_is_store), 32'(is_store_op(op)));
        chk("R3", $sformatf("vec%0d err_addr", i), err_addr, exp_ea(b, o));
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (e_stb && !is_store_op(op)) begin
        rsp_valid = 1'b1;
        rsp_data  = rd;
        #1;
        chk("R11", $sformatf("vec%0d ld_valid not early", i), 32'(ld_valid), 32'd0);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R11", $sformatf("vec%0d ld_valid", i), 32'(ld_valid), 32'd1);
        chk((op == 6'h20 || op == 6'h24) ? "R9" : ((op == 6'h23) ? "R11" : "R10"),
            $sformatf("vec%0d ld_data", i), ld_data, exp_load(op, rd));
        @(negedge clk);
        chk("R11", $sformatf("vec%0d ld_valid drops", i), 32'(ld_valid), 32'd0);
      end
    end

    // R5: byte store at every low address offset
    for (int k = 0; k < 4; k++) begin
      drive_req(6'h28, 32'h0000_7000 + 32'(k), 16'h0);
      #1;
      chk("R5", $sformatf("byte store offset %0d err", k), 32'(addr_err), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;

    // Concurrent: response of half signed load with a misaligned word store
    drive_req(6'h21, 32'h0000_0100, 16'h0000);
    @(negedge clk);
    drive_req(6'h2B, 32'h0000_0101, 16'h0000);
    rsp_valid = 1'b1; rsp_data = 32'h5555_FFFE;
    #1;
    chk("R4", "concurrent misaligned store err", 32'(addr_err), 32'd1);
    chk("R6", "concurrent err_is_store", 32'(err_is_store), 32'd1);
    chk("R4", "concurrent no strobe", 32'(mem_strobe), 32'd0);
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    chk("R10", "concurrent half result", ld_data, 32'hFFFF_FFFE);
    chk("R11", "concurrent ld_valid", 32'(ld_valid), 32'd1);

    // Concurrent: word load response with a new unsigned byte load
    drive_req(6'h23, 32'h0000_0200, 16'h0000);
    @(negedge clk);
    drive_req(6'h24, 32'h0000_0203, 16'h0000);
    rsp_valid = 1'b1; rsp_data = 32'hC001_D0FF;
    #1;
    chk("R7", "back-to-back load strobe", 32'(mem_strobe), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "older word result", ld_data, 32'hC001_D0FF);
    rsp_data = 32'h7777_77F0;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk("R9", "younger unsigned byte result", ld_data, 32'h0000_00F0);
    chk("R11", "younger ld_valid", 32'(ld_valid), 32'd1);

    // R1: wrap-around
    drive_req(6'h23, 32'hFFFF_FFFF, 16'h0001);
    #1;
    chk("R1", "wrap eff_addr", eff_addr, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_valid = 1'b1; rsp_data = 32'h0;
    @(negedge clk);
    rsp_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule